// File: doc/BRIEF.md
# Capture/Compare Timer Channel

A single 32-bit timer channel for a microcontroller peripheral bus. The counter advances on a tick that comes from a selectable source: the system clock, the system clock divided by a fixed ratio, or rising edges of an external clock pin. The selected source then passes through an 8-bit prescaler. The counter either runs freely and wraps, or restarts at zero after it has matched a reference value.

On a selected edge of the capture pin, the current count is latched into a capture register. When the counter reaches the reference value, the compare output pin either pulses or toggles. Each of the two events sets a status flag. Each flag can drive the interrupt line or, when routed to DMA, the DMA request line. An external DMA engine acknowledges a request with a pulse that clears the flags routed to it.

Top module: `cct_channel`

## Requirements
- R1: After reset, the control, reference, capture, counter and status registers read zero, and `cmp_out`, `irq` and `dma_req` are low.
- R2: Control bits [1:0] select the count source: 0 = stopped, 1 = every system clock, 2 = one pulse per 16 system clocks, 3 = rising edges of `ext_clk`, taken after a two-flop synchronizer.
- R3: Control bits [23:16] hold a prescale value P, and the counter advances once per P+1 source pulses. A write to the control register restarts both the prescaler and the divide-by-16 phase, and no tick occurs in the cycle of that write.
- R4: In free-run mode (control bit 5 = 0), a tick at 0xFFFFFFFF wraps the counter to 0.
- R5: In restart mode (control bit 5 = 1), a tick while the counter equals the reference returns the counter to 0. The count sequence is therefore 0..REF.
- R6: A compare event occurs when a tick brings the counter to the reference value. It sets status bit 1. A register write that loads the counter with the reference value is not a compare event.
- R7: Control bit 4 selects the output mode. With 0, `cmp_out` is high for exactly the one cycle after a compare event. With 1, `cmp_out` inverts on each compare event.
- R8: Control bits [3:2] select the capture edge: 0 = none, 1 = rising, 2 = falling, 3 = both. The pin passes through a two-flop synchronizer. The count is latched and status bit 0 is set on the third clock edge after the pin changes. Edges that are not selected have no effect.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle as a clear keeps the flag set.
- R10: Control bits 6 and 7 enable the interrupt for the capture and compare flags. Bits 8 and 9 route the capture and compare flags to `dma_req`. A flag routed to DMA does not drive `irq`.
- R11: A `dma_ack` pulse clears the flags that are routed to DMA and leaves the other flags unchanged.
- R12: The register map is: address 0 = control, 1 = reference, 2 = capture (read-only), 3 = counter (read/write), 4 = status. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cap_pin | input | 1 | Asynchronous capture input |
| ext_clk | input | 1 | Asynchronous external count clock |
| dma_ack | input | 1 | DMA acknowledge pulse |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The checker watches these behaviours on every cycle:
- counter wrap in free-run mode;
- return to zero in restart mode;
- flags persisting until they are cleared by a write or an acknowledge;
- the one-cycle width of the compare pulse;
- the acknowledge dropping the DMA request;
- an interrupt never being raised without a flag;
- the capture register holding its value between events.

Only the bench scenarios can show the following:
- the actual count rates for each source and prescale value;
- the synchronizer latency to capture and to external ticks;
- the values latched for each edge selection;
- the routing outcome seen on the two request lines.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int CNT_W = 32;
    localparam int PRE_W = 8;

    typedef enum logic [1:0] {SRC_OFF, SRC_SYS, SRC_SLOW, SRC_EXT} clk_src_e;
    typedef enum logic [1:0] {CAP_OFF, CAP_RISE, CAP_FALL, CAP_BOTH} cap_edge_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_REF  = 3'd1;
    localparam logic [2:0] A_CAPT = 3'd2;
    localparam logic [2:0] A_CNT  = 3'd3;
    localparam logic [2:0] A_STAT = 3'd4;

    localparam int FLAG_CAP = 0;
    localparam int FLAG_CMP = 1;

    localparam logic [31:0] CTRL_MASK = 32'h00FF_03FF;

    typedef struct packed {
        logic [7:0]       rsv_hi;
        logic [PRE_W-1:0] prescale;
        logic [5:0]       rsv_lo;
        logic             cmp_dma;
        logic             cap_dma;
        logic             cmp_ie;
        logic             cap_ie;
        logic             restart;
        logic             toggle;
        cap_edge_e        edge_sel;
        clk_src_e         clk_sel;
    } ctrl_t;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] ref_v;
        logic [CNT_W-1:0] cap_v;
        logic [CNT_W-1:0] cnt_v;
        logic [1:0]       flags;
        logic             out;
    } chan_state_t;
endpackage

// File: rtl/cct_tick_gen.sv
module cct_tick_gen
    import cct_pkg::*;
#(
    parameter int PW       = PRE_W,
    parameter int SLOW_DIV = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  clk_src_e      src_sel,
    input  logic [PW-1:0] prescale,
    input  logic          ext_clk,
    output logic          tick
);
    localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;

    typedef struct packed {
        logic [1:0]       ext_sync;
        logic             ext_prev;
        logic [DIV_W-1:0] div;
        logic [PW-1:0]    pre;
    } tg_state_t;

    tg_state_t s_d, s_q;
    logic      src_pulse;
    logic      slow_hit;

    always_comb begin
        s_d          = s_q;
        s_d.ext_sync = {s_q.ext_sync[0], ext_clk};
        s_d.ext_prev = s_q.ext_sync[1];
        slow_hit     = (s_q.div == DIV_W'(SLOW_DIV - 1));
        unique case (src_sel)
            SRC_OFF:  src_pulse = 1'b0;
            SRC_SYS:  src_pulse = 1'b1;
            SRC_SLOW: src_pulse = slow_hit;
            default:  src_pulse = s_q.ext_sync[1] & ~s_q.ext_prev;
        endcase
        tick = src_pulse && (s_q.pre == prescale) && !restart_i;
        if (restart_i) begin
            s_d.div = '0;
            s_d.pre = '0;
        end else begin
            s_d.div = slow_hit ? '0 : s_q.div + 1'b1;
            if (src_pulse) begin
                s_d.pre = tick ? '0 : s_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cct_edge_det.sv
module cct_edge_det
    import cct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  cap_edge_e edge_sel,
    output logic      evt
);
    typedef struct packed {
        logic [1:0] sync;
        logic       prev;
    } ed_state_t;

    ed_state_t s_d, s_q;
    logic      rise, fall;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[0], pin};
        s_d.prev = s_q.sync[1];
        rise     = s_q.sync[1] & ~s_q.prev;
        fall     = ~s_q.sync[1] & s_q.prev;
        unique case (edge_sel)
            CAP_OFF:  evt = 1'b0;
            CAP_RISE: evt = rise;
            CAP_FALL: evt = fall;
            default:  evt = rise | fall;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/cct_channel.sv
module cct_channel
    import cct_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             cap_pin,
    input  logic             ext_clk,
    input  logic             dma_ack,
    output logic             cmp_out,
    output logic             irq,
    output logic             dma_req
);
    chan_state_t      st_d, st_q;
    logic             tick, cap_evt, cmp_evt;
    logic             ctrl_wr, ref_wr, cnt_wr, stat_wr;
    logic [CNT_W-1:0] cnt_step;
    logic [1:0]       flag_clr, dma_route, ie_bits;
    logic [1:0]       stat_flags;

    assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign ref_wr  = reg_wr && (reg_addr == A_REF);
    assign cnt_wr  = reg_wr && (reg_addr == A_CNT);
    assign stat_wr = reg_wr && (reg_addr == A_STAT);

    cct_tick_gen #(.PW(PRE_W), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ctrl_wr),
        .src_sel   (st_q.ctrl.clk_sel),
        .prescale  (st_q.ctrl.prescale),
        .ext_clk   (ext_clk),
        .tick      (tick)
    );

    cct_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .edge_sel (st_q.ctrl.edge_sel),
        .evt      (cap_evt)
    );

    always_comb begin
        st_d      = st_q;
        cnt_step  = (st_q.ctrl.restart && (st_q.cnt_v == st_q.ref_v)) ? '0 : st_q.cnt_v + 1'b1;
        cmp_evt   = tick && !cnt_wr && (cnt_step == st_q.ref_v);
        dma_route = {st_q.ctrl.cmp_dma, st_q.ctrl.cap_dma};
        ie_bits   = {st_q.ctrl.cmp_ie, st_q.ctrl.cap_ie};

        if (ctrl_wr) st_d.ctrl  = ctrl_t'(reg_wdata & CTRL_MASK);
        if (ref_wr)  st_d.ref_v = reg_wdata;

        if (cnt_wr)    st_d.cnt_v = reg_wdata;
        else if (tick) st_d.cnt_v = cnt_step;

        if (cap_evt) st_d.cap_v = st_q.cnt_v;

        flag_clr = (stat_wr ? reg_wdata[1:0] : 2'b00) | (dma_ack ? dma_route : 2'b00);
        st_d.flags = (st_q.flags & ~flag_clr) | {cmp_evt, cap_evt};

        if (st_q.ctrl.toggle) st_d.out = cmp_evt ? ~st_q.out : st_q.out;
        else                  st_d.out = cmp_evt;

        unique case (reg_addr)
            A_CTRL:  reg_rdata = st_q.ctrl;
            A_REF:   reg_rdata = st_q.ref_v;
            A_CAPT:  reg_rdata = st_q.cap_v;
            A_CNT:   reg_rdata = st_q.cnt_v;
            A_STAT:  reg_rdata = {{(CNT_W-2){1'b0}}, st_q.flags};
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_flags = st_q.flags;
    assign cmp_out    = st_q.out;
    assign irq        = |(stat_flags & ie_bits & ~dma_route);
    assign dma_req    = |(stat_flags & dma_route);
endmodule

// File: rtl/cct_channel_chk.sv
module cct_channel_chk
    import cct_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             cap_evt,
    input logic             cmp_evt,
    input logic             reg_wr,
    input logic             ctrl_wr,
    input logic             cnt_wr,
    input logic             stat_wr,
    input logic [1:0]       wbits,
    input logic             dma_ack,
    input ctrl_t            ctrl,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ref_v,
    input logic [CNT_W-1:0] cap,
    input logic [1:0]       flags,
    input logic             cmp_out,
    input logic             irq,
    input logic             dma_req
);
    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctrl.restart && !cnt_wr && (cnt == '1)) |=> (cnt == '0));

    // R5
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ctrl.restart && !cnt_wr && (cnt == ref_v)) |=> (cnt == '0));

    // R6
    cmp_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_evt |=> flags[FLAG_CMP]);

    // R7
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.toggle && !ctrl_wr && !cmp_evt) |=> !cmp_out);

    // R8
    cap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.edge_sel == CAP_OFF) |-> !cap_evt);

    // R8
    capt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FLAG_CMP] && !(stat_wr && wbits[FLAG_CMP]) && !(dma_ack && ctrl.cmp_dma))
        |=> flags[FLAG_CMP]);

    // R10
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != 2'b00));

    // R11
    ack_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !reg_wr && !cap_evt && !cmp_evt) |=> !dma_req);
endmodule

bind cct_channel cct_channel_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cap_evt (cap_evt),
    .cmp_evt (cmp_evt),
    .reg_wr  (reg_wr),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr),
    .stat_wr (stat_wr),
    .wbits   (reg_wdata[1:0]),
    .dma_ack (dma_ack),
    .ctrl    (st_q.ctrl),
    .cnt     (st_q.cnt_v),
    .ref_v   (st_q.ref_v),
    .cap     (st_q.cap_v),
    .flags   (stat_flags),
    .cmp_out (cmp_out),
    .irq     (irq),
    .dma_req (dma_req)
);

// File: tb/cct_channel_bench.sv
`timescale 1ns/1ps
module cct_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_pin = 1'b0;
    logic        ext_clk = 1'b0;
    logic        dma_ack = 1'b0;
    logic        cmp_out, irq, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cct_channel u_cct_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
        .ext_clk(ext_clk), .dma_ack(dma_ack), .cmp_out(cmp_out),
        .irq(irq), .dma_req(dma_req)
    );

    // Counting vectors: control word, reference, cycles run, expected count (R2 R3 R5)
    localparam int NV = 8;
    localparam logic [31:0] V_CTRL [NV] = '{32'h0000_0001, 32'h0003_0001, 32'h0000_0021,
        32'h0000_0002, 32'h0001_0002, 32'h0002_0021, 32'h0000_0000, 32'h0000_0021};
    localparam logic [31:0] V_REF  [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd4,
        32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd2, 32'hFFFF_FFFF, 32'd0};
    localparam int          V_N    [NV] = '{10, 20, 12, 50, 100, 20, 30, 7};
    localparam logic [31:0] V_EXP  [NV] = '{32'd10, 32'd5, 32'd2, 32'd3, 32'd3, 32'd0, 32'd0, 32'd0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            chk("R1 reg", v, 32'h0);
        end
        chk("R1 cmp_out", {31'b0, cmp_out}, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 dma_req", {31'b0, dma_req}, 32'h0);

        // R2 R3 R5 counting vectors
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, 32'h0);
            wr(3'd3, 32'h0);
            wr(3'd1, V_REF[i]);
            wr(3'd0, V_CTRL[i]);
            wait_n(V_N[i]);
            rd(3'd3, v);
            chk($sformatf("R2/R3/R5 vector %0d", i), v, V_EXP[i]);
        end
        rd(3'd0, v);
        chk("R12 ctrl readback", v, 32'h0000_0021);

        // R6 counter load equal to reference is no compare event
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h3);
        wr(3'd1, 32'd9);
        wr(3'd3, 32'd9);
        wait_n(2);
        rd(3'd4, v);
        chk("R6 load no event", v, 32'h0);

        // R6 R7 compare in pulse mode, interrupt enabled (R10)
        wr(3'd3, 32'h0);
        wr(3'd1, 32'd3);
        wr(3'd0, 32'h0000_0081);
        wait_n(2);
        chk("R7 pulse before", {31'b0, cmp_out}, 32'h0);
        wait_n(1);
        chk("R7 pulse high", {31'b0, cmp_out}, 32'h1);
        rd(3'd4, v);
        chk("R6 cmp flag", v, 32'h2);
        chk("R10 irq", {31'b0, irq}, 32'h1);
        wait_n(1);
        chk("R7 pulse one cycle", {31'b0, cmp_out}, 32'h0);

        // R9 write-one-to-clear
        wr(3'd4, 32'h1);
        rd(3'd4, v);
        chk("R9 zero bit ignored", v, 32'h2);
        wr(3'd4, 32'h2);
        rd(3'd4, v);
        chk("R9 cleared", v, 32'h0);
        chk("R10 irq dropped", {31'b0, irq}, 32'h0);

        // R7 toggle mode with restart (R5)
        wr(3'd0, 32'h0);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0000_0031);
        wait_n(5);
        chk("R7 toggle high", {31'b0, cmp_out}, 32'h1);
        rd(3'd3, v);
        chk("R5 restart count", v, 32'd1);
        wait_n(3);
        chk("R7 toggle low", {31'b0, cmp_out}, 32'h0);

        // R10 R11 routing and acknowledge
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h3);
        wr(3'd3, 32'h0);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'h0000_02C5);
        wait_n(2);
        chk("R10 dma_req", {31'b0, dma_req}, 32'h1);
        chk("R10 irq masked by route", {31'b0, irq}, 32'h0);
        cap_pin = 1'b1;
        wait_n(3);
        rd(3'd4, v);
        chk("R10 both flags", v, 32'h3);
        chk("R10 irq from capture", {31'b0, irq}, 32'h1);
        dma_ack = 1'b1;
        wait_n(1);
        dma_ack = 1'b0;
        rd(3'd4, v);
        chk("R11 ack clears routed only", v, 32'h1);
        chk("R11 dma_req low", {31'b0, dma_req}, 32'h0);
        chk("R11 irq kept", {31'b0, irq}, 32'h1);
        cap_pin = 1'b0;
        wait_n(4);

        // R8 capture edges
        wr(3'd0, 32'h0);
        wr(3'd4, 32'h3);
        wr(3'd3, 32'h0000_1234);
        wr(3'd0, 32'h0000_0004);
        cap_pin = 1'b1;
        wait_n(2);
        rd(3'd4, v);
        chk("R8 latency not yet", v, 32'h0);
        wait_n(1);
        rd(3'd4, v);
        chk("R8 rise flag", v, 32'h1);
        rd(3'd2, v);
        chk("R8 rise value", v, 32'h0000_1234);
        wr(3'd4, 32'h1);
        wr(3'd3, 32'h0000_0055);
        cap_pin = 1'b0;
        wait_n(5);
        rd(3'd4, v);
        chk("R8 fall ignored flag", v, 32'h0);
        rd(3'd2, v);
        chk("R8 fall ignored value", v, 32'h0000_1234);
        wr(3'd0, 32'h0000_000C);
        cap_pin = 1'b1;
        wait_n(3);
        rd(3'd2, v);
        chk("R8 both edges value", v, 32'h0000_0055);
        wr(3'd4, 32'h1);
        wr(3'd3, 32'h0000_0077);
        wr(3'd0, 32'h0000_0008);
        cap_pin = 1'b0;
        wait_n(3);
        rd(3'd2, v);
        chk("R8 falling value", v, 32'h0000_0077);
        wr(3'd4, 32'h1);
        wr(3'd0, 32'h0);
        cap_pin = 1'b1;
        wait_n(5);
        rd(3'd4, v);
        chk("R8 edge off", v, 32'h0);

        // R2 external clock source
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0000_0003);
        for (int k = 0; k < 4; k++) begin
            ext_clk = 1'b1;
            wait_n(4);
            ext_clk = 1'b0;
            wait_n(4);
        end
        rd(3'd3, v);
        chk("R2 external edges", v, 32'd4);

        // R4 wrap in free-run mode
        wr(3'd0, 32'h0);
        wr(3'd1, 32'd5);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_0001);
        wait_n(1);
        rd(3'd3, v);
        chk("R4 wrap", v, 32'h0);

        done = 1'b1;
        finish_run();
    end
endmodule